// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a register of `WIDTH` stages (eight by default). It loads all stages in parallel or shifts them one place toward the last stage. Only the last stage drives a functional output. The block runs on a fast system clock. It has no clock of its own for the shift path. Instead, two slow clock-like pins come in from outside the system clock domain. Each pin passes through a two-flop synchronizer, and the block ORs the two synchronized levels. Every 0-to-1 transition of that OR makes a one-cycle strobe, and each strobe performs exactly one load or one shift. Either pin can therefore act as the clock while the other is low. Holding either pin high blocks every edge on the other, so each pin works as an inhibit for its partner.

The mode pin, the serial input and the parallel inputs are plain level pins. They are sampled on the system clock edge that applies the strobe. There is no valid/ready handshake and no back-pressure: the block takes its data when a clock event arrives and never stalls the source. The source must hold the data pins steady from the rising clock pin until the change appears. An active-low clear empties the register at once, without waiting for a clock. A test-only output exposes every stage.

Top module: `gated_piso_shreg`

## Requirements
- R1: While `clr_n` is low, every stage and `q_last_o` read 0 at once, whatever the other inputs do.
- R2: A shift-clock event is a 0-to-1 transition of (`tick_a_i` OR `tick_b_i`) after synchronization. A rising `tick_a_i` while `tick_b_i` is low is an event, and so is a rising `tick_b_i` while `tick_a_i` is low.
- R3: While one tick input stays high, transitions of the other tick input cause no event, and the stages hold.
- R4: On an event with `shift_en_i` = 0, stage i takes `par_i[i]`. Bit 0 goes to the first stage and bit `WIDTH-1` goes to the last stage.
- R5: On an event with `shift_en_i` = 1, stage 0 takes `ser_i` and each stage i > 0 takes the old value of stage i-1.
- R6: One event makes exactly one load or shift, however many system cycles the tick input stays high.
- R7: Without an event, the stages keep their values while `ser_i`, `par_i` and `shift_en_i` change.
- R8: `q_last_o` equals stage `WIDTH-1`, and bit i of `stages_o` is stage i. After a load and then k shifts (k < WIDTH), `q_last_o` shows `par_i[WIDTH-1-k]`. From shift WIDTH onward, it shows the serial bits in the order they were entered.
- R9: When a tick input rises between system clock edges, the result shows on the outputs right after the third following rising edge. It is not yet visible after the second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| clr_n | input | 1 | Asynchronous active-low clear |
| tick_a_i | input | 1 | First clock-like input; also an inhibit for tick_b_i |
| tick_b_i | input | 1 | Second clock-like input; also an inhibit for tick_a_i |
| shift_en_i | input | 1 | 1 = shift, 0 = parallel load |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data; bit i goes to stage i |
| q_last_o | output | 1 | Value of the last stage |
| stages_o | output | WIDTH | Test-only view of all stages |

## Verification
The assertions check the following on every cycle: the clear forces zeros, a tick held high suppresses strobes, a strobe never lasts two cycles, and the register stays still between strobes. They also compare each load or shift with the inputs sampled one cycle earlier. The bench scenarios are needed for the end-to-end behaviour: the three-edge latency from a pin change, the sequence of values from the last stage after a load, and the correct count of actions across long high pulses and inhibit windows on both pins.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } sr_mode_e;

  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned TICK_SRCS  = 2;
endpackage

// File: rtl/gcsr_sync.sv
module gcsr_sync #(
  parameter int unsigned NBITS = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [NBITS-1:0] async_i,
  output logic [NBITS-1:0] sync_o
);
  logic [DEPTH-1:0][NBITS-1:0] chain;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      chain <= '0;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < DEPTH; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[DEPTH-1];
endmodule

// File: rtl/gcsr_strobe.sv
module gcsr_strobe #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            clr_n,
  input  logic [NSRC-1:0] lvl_i,
  output logic            strobe_o
);
  logic comb_now, comb_q;

  // Sources are OR-combined: a high source masks edges on the others.
  assign comb_now = |lvl_i;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) comb_q <= 1'b0;
    else        comb_q <= comb_now;
  end

  assign strobe_o = comb_now & ~comb_q;
endmodule

// File: rtl/gcsr_stages.sv
module gcsr_stages
  import gcsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             strobe_i,
  input  sr_mode_e         mode_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] st_o
);
  logic [WIDTH-1:0] st, feed;

  for (genvar i = 0; i < WIDTH; i++) begin : g_feed
    if (i == 0) begin : g_head
      assign feed[i] = ser_i;
    end else begin : g_link
      assign feed[i] = st[i-1];
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)        st <= '0;
    else if (strobe_i) st <= (mode_i == MODE_SHIFT) ? feed : par_i;
  end

  assign st_o = st;
endmodule

// File: rtl/gated_piso_shreg.sv
module gated_piso_shreg
  import gcsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             tick_a_i,
  input  logic             tick_b_i,
  input  logic             shift_en_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             q_last_o,
  output logic [WIDTH-1:0] stages_o
);
  logic [TICK_SRCS-1:0] lvl_sync;
  logic                 strobe;
  logic [WIDTH-1:0]     st;

  gcsr_sync #(.NBITS(TICK_SRCS), .DEPTH(SYNC_DEPTH)) sync_i (
    .clk    (clk),
    .clr_n  (clr_n),
    .async_i({tick_b_i, tick_a_i}),
    .sync_o (lvl_sync)
  );

  gcsr_strobe #(.NSRC(TICK_SRCS)) strobe_i (
    .clk     (clk),
    .clr_n   (clr_n),
    .lvl_i   (lvl_sync),
    .strobe_o(strobe)
  );

  gcsr_stages #(.WIDTH(WIDTH)) stages_i (
    .clk     (clk),
    .clr_n   (clr_n),
    .strobe_i(strobe),
    .mode_i  (sr_mode_e'(shift_en_i)),
    .ser_i   (ser_i),
    .par_i   (par_i),
    .st_o    (st)
  );

  assign stages_o = st;
  assign q_last_o = st[WIDTH-1];
endmodule

// File: rtl/gated_piso_shreg_chk.sv
module gated_piso_shreg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic             strobe,
  input logic [1:0]       lvl,
  input logic             shift_en,
  input logic             ser,
  input logic [WIDTH-1:0] par,
  input logic [WIDTH-1:0] stages,
  input logic             q_last
);
  p_clear_r1: assert property (@(posedge clk)
    !clr_n |-> (stages == '0 && !q_last));

  p_inhibit_r3: assert property (@(posedge clk) disable iff (!clr_n)
    ((lvl[1] && $past(lvl[1])) || (lvl[0] && $past(lvl[0]))) |-> !strobe);

  p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (strobe && !shift_en) |=> stages == $past(par));

  p_shift_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (strobe && shift_en) |=> stages == {$past(stages[WIDTH-2:0]), $past(ser)});

  p_single_r6: assert property (@(posedge clk) disable iff (!clr_n)
    strobe |=> !strobe);

  p_hold_r7: assert property (@(posedge clk) disable iff (!clr_n)
    !strobe |=> $stable(stages));
endmodule

bind gated_piso_shreg gated_piso_shreg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk     (clk),
  .clr_n   (clr_n),
  .strobe  (strobe),
  .lvl     (lvl_sync),
  .shift_en(shift_en_i),
  .ser     (ser_i),
  .par     (par_i),
  .stages  (stages_o),
  .q_last  (q_last_o)
);

// File: tb/gated_piso_shreg_tb_top.sv
`timescale 1ns/1ps
module gated_piso_shreg_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         tick_a = 1'b0, tick_b = 1'b0;
  logic         shift_en = 1'b0, ser = 1'b0;
  logic [W-1:0] par = '0;
  logic         q_last;
  logic [W-1:0] stages;
  logic [W-1:0] model = '0;
  int           n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gated_piso_shreg #(.WIDTH(W)) dut_i (
    .clk(clk), .clr_n(clr_n), .tick_a_i(tick_a), .tick_b_i(tick_b),
    .shift_en_i(shift_en), .ser_i(ser), .par_i(par),
    .q_last_o(q_last), .stages_o(stages)
  );

  function automatic logic [W-1:0] f_next(input logic [W-1:0] cur, input logic sh,
                                          input logic s, input logic [W-1:0] p);
    return sh ? {cur[W-2:0], s} : p;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, stages, model);
    chk({tag, " R8 q_last"}, {{(W-1){1'b0}}, q_last}, {{(W-1){1'b0}}, model[W-1]});
  endtask

  task automatic set_data(input logic sh, input logic s, input logic [W-1:0] p);
    @(negedge clk);
    shift_en = sh; ser = s; par = p;
  endtask

  // One clock pulse on a chosen pin, held high long (R6), data steady throughout.
  task automatic pulse(input bit use_b, input logic sh, input logic s, input logic [W-1:0] p);
    set_data(sh, s, p);
    @(negedge clk);
    if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
    repeat (7) @(negedge clk);
    if (use_b) tick_b = 1'b0; else tick_a = 1'b0;
    repeat (4) @(negedge clk);
    model = f_next(model, sh, s, p);
  endtask

  // Raise one pin (an event), toggle the other several times (inhibited), release.
  task automatic inhibit_seq(input bit hold_b, input logic sh, input logic s, input logic [W-1:0] p);
    set_data(sh, s, p);
    @(negedge clk);
    if (hold_b) tick_b = 1'b1; else tick_a = 1'b1;
    repeat (4) @(negedge clk);
    model = f_next(model, sh, s, p);
    for (int k = 0; k < 3; k++) begin
      shift_en = 1'($urandom); ser = 1'($urandom); par = W'($urandom);
      if (hold_b) tick_a = 1'b1; else tick_b = 1'b1;
      repeat (4) @(negedge clk);
      if (hold_b) tick_a = 1'b0; else tick_b = 1'b0;
      repeat (4) @(negedge clk);
    end
    if (hold_b) tick_b = 1'b0; else tick_a = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [W-1:0] ld;
    logic [W-1:0] sbits;
    void'($urandom(32'd20240611));

    // R1: reset state, ticks toggling during clear have no effect
    #1 chk("R1 reset state", stages, '0);
    par = '1; shift_en = 1'b0;
    repeat (2) @(negedge clk);
    tick_a = 1'b1;
    repeat (5) @(negedge clk);
    tick_a = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 clear overrides clock", stages, '0);
    clr_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4, R8: load then WIDTH+3 shifts; last stage shows H..A then serial bits
    ld = 8'hB4; sbits = 8'h5A;
    pulse(1'b0, 1'b0, 1'b0, ld);
    check_all("R4 load");
    chk("R8 first out is top bit", {{(W-1){1'b0}}, q_last}, {{(W-1){1'b0}}, ld[W-1]});
    for (int k = 1; k <= W + 3; k++) begin
      pulse(1'b0, 1'b1, sbits[(k-1) % W], ld);
      check_all("R5 shift");
      if (k < W)
        chk("R8 parallel bit order", {{(W-1){1'b0}}, q_last}, {{(W-1){1'b0}}, ld[W-1-k]});
      else
        chk("R8 serial bit order", {{(W-1){1'b0}}, q_last},
            {{(W-1){1'b0}}, sbits[(k-W) % W]});
    end

    // R2: tick_b alone works as the clock
    pulse(1'b1, 1'b0, 1'b0, 8'h3C);
    check_all("R2 tick_b as clock");

    // R9: latency of three rising edges
    set_data(1'b0, 1'b0, 8'hC3);
    @(negedge clk);
    tick_a = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 not yet after two edges", stages, model);
    @(negedge clk);
    model = 8'hC3;
    chk("R9 visible after third edge", stages, model);
    repeat (3) @(negedge clk);
    tick_a = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R6 one action per long pulse");

    // R3: each pin inhibits the other
    inhibit_seq(1'b1, 1'b1, 1'b1, 8'h00);
    check_all("R3 tick_b inhibits tick_a");
    inhibit_seq(1'b0, 1'b0, 1'b0, 8'h96);
    check_all("R3 tick_a inhibits tick_b");

    // R1: asynchronous clear mid-stream
    @(negedge clk);
    clr_n = 1'b0;
    #1 model = '0;
    check_all("R1 async clear");
    @(negedge clk);
    clr_n = 1'b1;
    repeat (3) @(negedge clk);

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0, 1: begin
          pulse(1'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
          check_all("R4/R5 random event");
        end
        2: begin
          inhibit_seq(1'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
          check_all("R3 random inhibit");
        end
        3: begin
          for (int j = 0; j < 4; j++) set_data(1'($urandom), 1'($urandom), W'($urandom));
          repeat (3) @(negedge clk);
          check_all("R7 hold without event");
        end
        default: begin
          if (($urandom % 4) == 0) begin
            clr_n = 1'b0;
            #1 model = '0;
            check_all("R1 random clear");
            @(negedge clk);
            clr_n = 1'b1;
            repeat (3) @(negedge clk);
          end else begin
            pulse(1'b0, 1'b1, 1'($urandom), W'($urandom));
            check_all("R5 random shift");
          end
        end
      endcase
    end

    finish_up();
  end
endmodule